// File: doc/BRIEF.md
# Multi-Driver Net Strength Resolver

This block merges several drivers that share one net into a single resolved value and a strength code. Each driver is a buffer with two strength settings of its own: one applies when it drives 0 and the other when it drives 1. The driver stage turns its input into a (value, strength) pair. The resolver ranks all participating pairs on a numeric strength scale. The highest rank wins. Equal-rank disagreement gives X at that rank.

Each driver input is a two-bit four-state code. An input of X or Z is a partial value, and it forces the resolved value to X. Each driver has an enable. A configuration check raises an error output when a driver has no usable strength for either value.

The resolved value, strength and error flag are registered once, which gives a one-cycle latency from inputs to outputs.

Top module: `net_strength_resolver`

## Requirements
- R1: All outputs are registered and follow the inputs one clock later. While the synchronous active-high `rst` is high, the next edge loads value Z (code 10), strength 0 and `cfg_err` = 0.
- R2: Strength setting codes are supply = 7, strong = 6, pull = 5, weak = 3 and highz = 0. The codes 1, 2 and 4 are reserved and are treated as highz. A driver whose input is 0 uses its 0-setting, and a driver whose input is 1 uses its 1-setting.
- R3: `cfg_err` is 1 when any driver has both its settings decoding to highz, whether or not that driver is enabled.
- R4: A driver takes no part in resolution when it is disabled or when its applicable strength is highz. When no driver takes part, the output is value Z with strength 0.
- R5: When the participating drivers differ in strength, the output takes the value and strength of the strongest one.
- R6: When all drivers at the highest strength drive the same value, the output is that value at that strength.
- R7: When drivers at the highest strength drive both 0 and 1, the output value is X and the output strength is that shared strength.
- R8: A driver input of X (11) or Z (10) is partial. A partial driver participates with the greater of its two settings. If any participating driver is partial, the output value is X and the output strength is the highest participating strength.
- R9: Value codes on the inputs and outputs are 00 = 0, 01 = 1, 10 = Z and 11 = X. Driver i uses bits [2i+1:2i] of `drv_in` and bits [3i+2:3i] of the strength vectors.
- R10: The output strength is never 1, 2 or 4, and it is 0 exactly when the output value is Z.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_in | input | 2*NDRV | Per-driver four-state input code |
| drv_en | input | NDRV | Per-driver enable |
| str_lo | input | 3*NDRV | Per-driver strength used when driving 0 |
| str_hi | input | 3*NDRV | Per-driver strength used when driving 1 |
| net_val | output | 2 | Resolved value code |
| net_str | output | 3 | Resolved strength code |
| cfg_err | output | 1 | Illegal both-highz configuration flag |

## Verification
The sweep pairs every input code, enable and legal strength setting of two drivers against each other, with a third driver idle.

This sweep covers the following cases:
- Equal-rank ties with opposite values. A resolver that picks the lower index, or that ORs the values, would report 0 or 1 where X is required.
- Drivers where one setting is highz and the other is not. A stage that applies the wrong setting for the driven value would lose or win contention wrongly.
- Partial inputs that are weaker than a clean driver. A design that only lets the top rank taint the value would report a clean value instead of X.

A pseudo-random phase with all three drivers uses the reserved codes 1, 2 and 4. A decoder that passed these codes through would report a charge-storage strength. The reset and latency checks catch an output stage that is missing or transparent.

// File: rtl/strres_pkg.sv
package strres_pkg;

  typedef enum logic [1:0] {
    V_ZERO = 2'b00,
    V_ONE  = 2'b01,
    V_Z    = 2'b10,
    V_X    = 2'b11
  } val_t;

  localparam int STRW = 3;

  localparam logic [STRW-1:0] S_HIGHZ  = 3'd0;
  localparam logic [STRW-1:0] S_WEAK   = 3'd3;
  localparam logic [STRW-1:0] S_PULL   = 3'd5;
  localparam logic [STRW-1:0] S_STRONG = 3'd6;
  localparam logic [STRW-1:0] S_SUPPLY = 3'd7;

  // Reserved charge codes collapse to highz; only driving ranks pass.
  function automatic logic [STRW-1:0] decode_strength(input logic [STRW-1:0] code);
    logic [STRW-1:0] r;
    unique case (code)
      S_WEAK, S_PULL, S_STRONG, S_SUPPLY: r = code;
      default:                            r = S_HIGHZ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/drv_stage.sv
module drv_stage
  import strres_pkg::*;
(
  input  logic            en,
  input  logic [1:0]      din,
  input  logic [STRW-1:0] s_lo,
  input  logic [STRW-1:0] s_hi,
  output logic            act,
  output logic            bitv,
  output logic            part,
  output logic [STRW-1:0] str,
  output logic            ill
);

  logic [STRW-1:0] d_lo, d_hi;

  always_comb begin
    d_lo = decode_strength(s_lo);
    d_hi = decode_strength(s_hi);
    ill  = (d_lo == S_HIGHZ) && (d_hi == S_HIGHZ);
    part = 1'b0;
    bitv = 1'b0;
    unique case (din)
      2'b00: str = d_lo;
      2'b01: begin
        str  = d_hi;
        bitv = 1'b1;
      end
      default: begin
        part = 1'b1;
        str  = (d_lo > d_hi) ? d_lo : d_hi;
      end
    endcase
    act = en && (str != S_HIGHZ);
  end

endmodule

// File: rtl/strength_resolver.sv
module strength_resolver
  import strres_pkg::*;
#(
  parameter int NDRV = 4
) (
  input  logic [NDRV-1:0]      act,
  input  logic [NDRV-1:0]      bitv,
  input  logic [NDRV-1:0]      part,
  input  logic [NDRV*STRW-1:0] str,
  output logic [1:0]           res_val,
  output logic [STRW-1:0]      res_str
);

  logic [STRW-1:0] top;
  logic            any_act, any_part, top0, top1;

  // First pass: highest participating rank.
  always_comb begin
    top      = S_HIGHZ;
    any_act  = 1'b0;
    any_part = 1'b0;
    for (int i = 0; i < NDRV; i++) begin
      if (act[i]) begin
        any_act = 1'b1;
        if (part[i]) any_part = 1'b1;
        if (str[i*STRW +: STRW] > top) top = str[i*STRW +: STRW];
      end
    end
  end

  // Second pass: which values appear at that rank.
  always_comb begin
    top0 = 1'b0;
    top1 = 1'b0;
    for (int i = 0; i < NDRV; i++) begin
      if (act[i] && !part[i] && str[i*STRW +: STRW] == top) begin
        if (bitv[i]) top1 = 1'b1;
        else         top0 = 1'b1;
      end
    end
  end

  always_comb begin
    res_str = top;
    if (!any_act)                res_val = V_Z;
    else if (any_part)           res_val = V_X;
    else if (top0 && top1)       res_val = V_X;
    else if (top1)               res_val = V_ONE;
    else                         res_val = V_ZERO;
  end

endmodule

// File: rtl/net_strength_resolver.sv
module net_strength_resolver
  import strres_pkg::*;
#(
  parameter int NDRV = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*NDRV-1:0]    drv_in,
  input  logic [NDRV-1:0]      drv_en,
  input  logic [STRW*NDRV-1:0] str_lo,
  input  logic [STRW*NDRV-1:0] str_hi,
  output logic [1:0]           net_val,
  output logic [STRW-1:0]      net_str,
  output logic                 cfg_err
);

  logic [NDRV-1:0]      st_act, st_bit, st_part, st_ill;
  logic [STRW*NDRV-1:0] st_str;
  logic [1:0]           res_val;
  logic [STRW-1:0]      res_str;

  for (genvar g = 0; g < NDRV; g++) begin : g_stage
    drv_stage u_stage (
      .en   (drv_en[g]),
      .din  (drv_in[2*g +: 2]),
      .s_lo (str_lo[STRW*g +: STRW]),
      .s_hi (str_hi[STRW*g +: STRW]),
      .act  (st_act[g]),
      .bitv (st_bit[g]),
      .part (st_part[g]),
      .str  (st_str[STRW*g +: STRW]),
      .ill  (st_ill[g])
    );

    // R5: no participant outranks the resolved strength
    assert_winner_rank_R5: assert property (@(posedge clk) disable iff (rst)
      st_act[g] |-> (res_str >= st_str[STRW*g +: STRW]));
  end

  strength_resolver #(.NDRV(NDRV)) u_res (
    .act     (st_act),
    .bitv    (st_bit),
    .part    (st_part),
    .str     (st_str),
    .res_val (res_val),
    .res_str (res_str)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      net_val <= V_Z;
      net_str <= S_HIGHZ;
      cfg_err <= 1'b0;
    end else begin
      net_val <= res_val;
      net_str <= res_str;
      cfg_err <= |st_ill;
    end
  end

  assert_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (net_val == $past(res_val) && net_str == $past(res_str)));

  assert_cfg_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (|st_ill) |=> cfg_err);

  assert_no_charge_code_R10: assert property (@(posedge clk) disable iff (rst)
    !(net_str inside {3'd1, 3'd2, 3'd4}));

  assert_z_iff_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (net_val == V_Z) == (net_str == S_HIGHZ));

  assert_partial_x_R8: assert property (@(posedge clk) disable iff (rst)
    (|(st_act & st_part)) |=> (net_val == V_X));

endmodule

// File: tb/net_strength_resolver_tb.sv
`timescale 1ns/1ps
module net_strength_resolver_tb;

  localparam int N = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [2*N-1:0] drv_in = '0;
  logic [N-1:0]   drv_en = '0;
  logic [3*N-1:0] str_lo = '0;
  logic [3*N-1:0] str_hi = '0;
  logic [1:0]     net_val;
  logic [2:0]     net_str;
  logic           cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'h1ace_2b0f;

  always #2 clk = ~clk;

  net_strength_resolver #(.NDRV(N)) u_dut (
    .clk(clk), .rst(rst), .drv_in(drv_in), .drv_en(drv_en),
    .str_lo(str_lo), .str_hi(str_hi),
    .net_val(net_val), .net_str(net_str), .cfg_err(cfg_err)
  );

  // R2: only 3,5,6,7 are driving ranks; everything else counts as highz
  function automatic int rank(input logic [2:0] c);
    if (c == 3 || c == 5 || c == 6 || c == 7) return int'(c);
    return 0;
  endfunction

  function automatic logic [2:0] legal(input int k);
    case (k)
      0: return 3'd0;
      1: return 3'd3;
      2: return 3'd5;
      3: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  // Reference: scan ranks from strongest down, first populated rank decides.
  // R9 codes: 00=0 01=1 10=Z 11=X
  task automatic reference(output logic [1:0] ev, output logic [2:0] es,
                           output logic ee, output string tag);
    int r_of [N];
    bit p_of [N];
    ee = 1'b0;
    for (int i = 0; i < N; i++) begin
      int a = rank(str_lo[3*i +: 3]);
      int b = rank(str_hi[3*i +: 3]);
      if (a == 0 && b == 0) ee = 1'b1;
      p_of[i] = drv_in[2*i+1];
      if (drv_in[2*i +: 2] == 2'b00)      r_of[i] = a;
      else if (drv_in[2*i +: 2] == 2'b01) r_of[i] = b;
      else                                r_of[i] = (a > b) ? a : b;
      if (!drv_en[i]) r_of[i] = 0;
    end
    ev = 2'b10; es = 3'd0; tag = "R4";
    for (int lv = 7; lv >= 1; lv--) begin
      int n0 = 0, n1 = 0;
      bit anyp = 0;
      for (int i = 0; i < N; i++) if (r_of[i] == lv) begin
        if (p_of[i]) anyp = 1;
        else if (drv_in[2*i]) n1++;
        else n0++;
      end
      if (anyp || n0 + n1 > 0) begin
        es = 3'(lv);
        if (anyp) begin ev = 2'b11; tag = "R8"; end
        else if (n0 > 0 && n1 > 0) begin ev = 2'b11; tag = "R7"; end
        else begin
          ev = (n1 > 0) ? 2'b01 : 2'b00;
          tag = (n0 + n1 > 1) ? "R6" : "R5";
        end
        break;
      end
    end
    // Weaker partial drivers still taint the value (R8)
    if (ev != 2'b10) for (int i = 0; i < N; i++)
      if (r_of[i] > 0 && p_of[i]) begin ev = 2'b11; tag = "R8"; end
  endtask

  task automatic check_now(input string tag, input logic [1:0] ev,
                           input logic [2:0] es, input logic ee);
    checks++;
    if (net_val !== ev || net_str !== es || cfg_err !== ee) begin
      errors++;
      $display("FAIL %s: val=%b str=%0d err=%b expected val=%b str=%0d err=%b",
               tag, net_val, net_str, cfg_err, ev, es, ee);
    end
  endtask

  task automatic step_and_check();
    logic [1:0] ev; logic [2:0] es; logic ee; string tag;
    reference(ev, es, ee, tag);
    @(posedge clk);
    @(negedge clk);
    if (ee !== cfg_err) tag = "R3";
    check_now(tag, ev, es, ee);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  initial begin
    @(negedge clk);
    // R1: reset with an active driver and an illegal config present
    drv_en = 3'b011; drv_in = 6'b000001;
    str_lo = {3'd0, 3'd0, 3'd6}; str_hi = {3'd0, 3'd0, 3'd6};
    @(posedge clk); @(negedge clk);
    check_now("R1", 2'b10, 3'd0, 1'b0);
    rst = 1'b0;
    // R1: before the next edge the output must still show reset values
    check_now("R1", 2'b10, 3'd0, 1'b0);
    step_and_check();

    // Exhaustive sweep over two drivers, third disabled with legal config
    drv_en[2] = 1'b0; str_lo[8:6] = 3'd5; str_hi[8:6] = 3'd3; drv_in[5:4] = 2'b00;
    for (int a = 0; a < 200; a++) begin
      for (int b = 0; b < 200; b++) begin
        drv_in[1:0] = 2'(a % 4);  drv_en[0] = (a / 4) % 2 == 1;
        str_lo[2:0] = legal((a / 8) % 5); str_hi[2:0] = legal(a / 40);
        drv_in[3:2] = 2'(b % 4);  drv_en[1] = (b / 4) % 2 == 1;
        str_lo[5:3] = legal((b / 8) % 5); str_hi[5:3] = legal(b / 40);
        step_and_check();
      end
    end

    // Pseudo-random over all three drivers with reserved codes (R2, R10)
    for (int k = 0; k < 6000; k++) begin
      lfsr = nxt(lfsr);
      drv_in = lfsr[5:0]; drv_en = lfsr[8:6];
      str_lo = lfsr[17:9]; str_hi = lfsr[26:18];
      step_and_check();
      checks++;
      if (net_str == 3'd1 || net_str == 3'd2 || net_str == 3'd4) begin
        errors++;
        $display("FAIL R10: str=%0d expected a driving rank or 0", net_str);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule